// File: doc/BRIEF.md
# Low-Power RAM Power-State Sequencer

This block sits between a host and a low-power static RAM. It owns two control pins of the RAM: the active-low chip select and the active-low sleep pin. From them it steps the RAM through five states. The first is a power-on wait. Then come idle standby, active access, a sleep state and a recovery wait that follows deep sleep. The host sees only a ready flag and a data-valid flag. The ready flag says when an access may be driven. The data-valid flag says whether the array still holds what was last written.

The host asks for an access by holding a level request. It asks for sleep with a one-cycle pulse, together with a select that chooses deep sleep or a data-retaining sleep. A second pulse asks to leave sleep. Chip select is always high before the sleep pin falls, and the sleep pin stays low for a minimum time. Deep sleep drops the array contents and is followed by a long recovery wait. The retaining sleep and standby can be left without any wait. Every wait length is a cycle-count parameter. The defaults match 200 us and 10 us at a 125 MHz clock.

Top module: `lpram_pwr_seq`

## Requirements
- R1: After reset is released, ready stays 0 and chip select (ram_cs_n) stays 1 for exactly PWRUP_CYC clock cycles. ready becomes 1 on clock edge number PWRUP_CYC after the release.
- R2: In standby, ram_cs_n=1, ram_lp_n=1 and ready=1. A high acc_req moves to the active state on the next edge, with ram_cs_n=0. Dropping acc_req returns to standby on the next edge.
- R3: ram_lp_n only falls while ram_cs_n is 1 and was 1 in the cycle before. A sleep_go pulse during the active state is ignored: ram_cs_n stays 0 and ram_lp_n stays 1.
- R4: Once ram_lp_n falls, it stays low for at least HOLD_CYC cycles. A wake_go pulse that arrives earlier is remembered, and sleep ends at edge HOLD_CYC after entry.
- R5: Leaving a data-retaining sleep (sleep_deep=0 at entry) raises ram_lp_n and ready on the same edge, and data_valid keeps its value.
- R6: Leaving deep sleep (sleep_deep=1 at entry) raises ram_lp_n. ready then stays 0 and ram_cs_n stays 1 for REC_CYC cycles, and ready rises at edge REC_CYC after the exit.
- R7: data_valid is 0 after reset and is cleared on the edge that enters deep sleep. It is set by valid_ack only when ready is 1; a valid_ack while ready is 0 is ignored.
- R8: An acc_req held during a wait (power-up or recovery) keeps ram_cs_n at 1. The access starts (ram_cs_n=0) on the edge after ready rises.
- R9: In standby, sleep_go takes priority over acc_req when both are high.
- R10: A wake_go pulse outside the sleep state has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, treated as power-on |
| acc_req | input | 1 | Host access request, level |
| sleep_go | input | 1 | Sleep request pulse, taken in standby only |
| sleep_deep | input | 1 | With sleep_go: 1 selects deep sleep, 0 selects data-retaining sleep |
| wake_go | input | 1 | Request to leave sleep, pulse |
| valid_ack | input | 1 | Host acknowledge that marks array contents valid |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_lp_n | output | 1 | RAM sleep pin, active low |
| ready | output | 1 | Accesses allowed |
| data_valid | output | 1 | Array contents known good |

## Verification
The assertions assume the host issues sleep_go and wake_go as single-cycle pulses. They also assume the host leaves sleep_deep constant during the pulse that starts a sleep. The stimulus drives every pulse for exactly one cycle and changes inputs only at the falling clock edge. Wait parameters are shrunk in the bench so that the power-up, minimum-sleep and recovery windows can be walked edge by edge.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_STBY  = 3'd1,
    ST_ACT   = 3'd2,
    ST_SLEEP = 3'd3,
    ST_RECOV = 3'd4
  } seq_state_t;

  // number of cycles a state must last before its timer reports done
  function automatic int unsigned wait_len(seq_state_t s, int unsigned pu,
                                           int unsigned rec, int unsigned hold);
    case (s)
      ST_INIT:  return pu;
      ST_RECOV: return rec;
      ST_SLEEP: return hold;
      default:  return 1;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lpseq_timer.sv
module lpseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] last,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt != last) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == last);
endmodule

// File: rtl/lpseq_valid.sv
module lpseq_valid (
  input  logic clk,
  input  logic rst_n,
  input  logic dpd_enter,
  input  logic ack_ok,
  output logic data_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_valid <= 1'b0;
    else if (dpd_enter) data_valid <= 1'b0;
    else if (ack_ok)    data_valid <= 1'b1;
  end

  // R7: deep sleep entry wipes the valid flag
  assert_dpd_clears_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dpd_enter |=> !data_valid);
endmodule

// File: rtl/lpram_pwr_seq.sv
module lpram_pwr_seq
  import lpseq_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 25000,
  parameter int unsigned REC_CYC   = 25000,
  parameter int unsigned HOLD_CYC  = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic sleep_go,
  input  logic sleep_deep,
  input  logic wake_go,
  input  logic valid_ack,
  output logic ram_cs_n,
  output logic ram_lp_n,
  output logic ready,
  output logic data_valid
);
  localparam int unsigned MAXW = max3(PWRUP_CYC, REC_CYC, HOLD_CYC);
  localparam int          CW   = (MAXW < 2) ? 1 : $clog2(MAXW);

  seq_state_t st, nxt;
  logic       deep_q;
  logic       wake_pend;
  logic       tmr_done;
  logic       tmr_clr;
  logic [CW-1:0] tmr_last;

  // named internal events
  logic sleep_take;
  logic dpd_enter;
  logic ack_ok;
  logic wake_seen;

  assign sleep_take = (st == ST_STBY) && sleep_go;
  assign dpd_enter  = sleep_take && sleep_deep;
  assign wake_seen  = wake_pend || wake_go;

  always_comb begin
    nxt = st;
    case (st)
      ST_INIT:  if (tmr_done) nxt = ST_STBY;
      ST_STBY:  if (sleep_go) nxt = ST_SLEEP;
                else if (acc_req) nxt = ST_ACT;
      ST_ACT:   if (!acc_req) nxt = ST_STBY;
      ST_SLEEP: if (tmr_done && wake_seen) nxt = deep_q ? ST_RECOV : ST_STBY;
      ST_RECOV: if (tmr_done) nxt = ST_STBY;
      default:  nxt = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_INIT;
      deep_q    <= 1'b0;
      wake_pend <= 1'b0;
    end else begin
      st <= nxt;
      if (sleep_take) deep_q <= sleep_deep;
      if (st != ST_SLEEP) wake_pend <= 1'b0;
      else if (wake_go)   wake_pend <= 1'b1;
    end
  end

  assign tmr_clr  = (nxt != st);
  assign tmr_last = CW'(wait_len(st, PWRUP_CYC, REC_CYC, HOLD_CYC) - 1);

  lpseq_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .last  (tmr_last),
    .done  (tmr_done)
  );

  assign ram_cs_n = (st != ST_ACT);
  assign ram_lp_n = (st != ST_SLEEP);
  assign ready    = (st == ST_STBY) || (st == ST_ACT);
  assign ack_ok   = valid_ack && ready;

  lpseq_valid u_val (
    .clk        (clk),
    .rst_n      (rst_n),
    .dpd_enter  (dpd_enter),
    .ack_ok     (ack_ok),
    .data_valid (data_valid)
  );

  // R3: chip select already high when the sleep pin falls
  assert_cs_before_lp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_lp_n) |-> (ram_cs_n && $past(ram_cs_n)));

  // R4: sleep pin held low until the minimum-time timer reports done
  assert_lp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_lp_n && !tmr_done) |=> !ram_lp_n);

  // R5: retaining sleep exit gives ready at once
  assert_fast_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ram_lp_n) && !deep_q) |-> ready);

  // R6: deep sleep exit blocks ready
  assert_deep_recov_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ram_lp_n) && deep_q) |-> !ready);

  // R8: no chip select while accesses are blocked
  assert_no_cs_when_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> ram_cs_n);
endmodule

// File: tb/sim_lpram_pwr_seq.sv
module sim_lpram_pwr_seq;
  localparam int unsigned PU   = 20;
  localparam int unsigned REC  = 12;
  localparam int unsigned HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_req = 0, sleep_go = 0, sleep_deep = 0, wake_go = 0, valid_ack = 0;
  logic ram_cs_n, ram_lp_n, ready, data_valid;
  int   n_chk = 0, n_fail = 0;
  bit   done_flag = 0;

  always #4 clk = ~clk;

  lpram_pwr_seq #(.PWRUP_CYC(PU), .REC_CYC(REC), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .sleep_go(sleep_go),
    .sleep_deep(sleep_deep), .wake_go(wake_go), .valid_ack(valid_ack),
    .ram_cs_n(ram_cs_n), .ram_lp_n(ram_lp_n), .ready(ready), .data_valid(data_valid)
  );

  // {acc, sleep_go, wake_go, deep, ack, exp_cs_n, exp_lp_n, exp_ready, exp_valid}
  localparam logic [8:0] VEC [12] = '{
    9'b00001_1111,  // R7 ack in standby
    9'b10000_0111,  // R2 enter active
    9'b11000_0111,  // R3 sleep in active ignored
    9'b00000_1111,  // R2 back to standby
    9'b11000_1001,  // R9 sleep wins over access
    9'b00100_1001,  // R4 early wake
    9'b00000_1001,  // R4
    9'b00000_1001,  // R4
    9'b00000_1111,  // R5 fast exit
    9'b00100_1111,  // R10 stray wake
    9'b10000_0111,  // R2
    9'b00000_1111   // R2
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R7";
      2: return "R3";
      4: return "R9";
      5, 6, 7: return "R4";
      8: return "R5";
      9: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    acc_req = 1;  // R8: request held across power-up
    repeat (3) @(negedge clk);
    chk("R1", "cs_n in reset", ram_cs_n, 1'b1);
    chk("R1", "ready in reset", ready, 1'b0);
    chk("R7", "valid in reset", data_valid, 1'b0);
    chk("R3", "lp_n in reset", ram_lp_n, 1'b1);
    rst_n = 1;
    repeat (PU - 1) step();
    chk("R1", "ready before wait end", ready, 1'b0);
    chk("R8", "cs_n held during power-up", ram_cs_n, 1'b1);
    step();
    chk("R1", "ready at wait end", ready, 1'b1);
    chk("R8", "cs_n at wait end", ram_cs_n, 1'b1);
    step();
    chk("R8", "held access starts", ram_cs_n, 1'b0);
    acc_req = 0;
    step();
    chk("R2", "back to standby", ram_cs_n, 1'b1);

    for (int i = 0; i < 12; i++) begin
      logic a, s, w, d, k, ecs, elp, erd, eva;
      {a, s, w, d, k, ecs, elp, erd, eva} = VEC[i];
      acc_req = a; sleep_go = s; wake_go = w; sleep_deep = d; valid_ack = k;
      step();
      sleep_go = 0; wake_go = 0; valid_ack = 0;
      chk(vec_tag(i), "cs_n", ram_cs_n, ecs);
      chk(vec_tag(i), "lp_n", ram_lp_n, elp);
      chk(vec_tag(i), "ready", ready, erd);
      chk(vec_tag(i), "data_valid", data_valid, eva);
    end
    acc_req = 0;

    // deep sleep with early wake and ignored ack
    sleep_go = 1; sleep_deep = 1;
    step();
    sleep_go = 0; sleep_deep = 0;
    chk("R7", "valid cleared at deep entry", data_valid, 1'b0);
    chk("R3", "lp_n low with cs_n high", ram_lp_n | ~ram_cs_n, 1'b0);
    wake_go = 1; valid_ack = 1;
    step();
    wake_go = 0;
    chk("R7", "ack while asleep ignored", data_valid, 1'b0);
    repeat (HOLD - 2) step();
    chk("R4", "lp_n still low at hold-1", ram_lp_n, 1'b0);
    acc_req = 1;
    step();
    chk("R6", "lp_n released", ram_lp_n, 1'b1);
    chk("R6", "ready blocked after deep exit", ready, 1'b0);
    repeat (REC - 1) step();
    chk("R6", "ready blocked at rec-1", ready, 1'b0);
    chk("R8", "cs_n held during recovery", ram_cs_n, 1'b1);
    chk("R7", "valid still clear after recovery ack", data_valid, 1'b0);
    step();
    chk("R6", "ready at recovery end", ready, 1'b1);
    chk("R7", "ack before ready ignored", data_valid, 1'b0);
    step();
    chk("R8", "held access after recovery", ram_cs_n, 1'b0);
    chk("R7", "ack once ready", data_valid, 1'b1);
    acc_req = 0; valid_ack = 0;
    step();
    chk("R2", "standby after access", ram_cs_n, 1'b1);
    finish_run();
  end
endmodule